// File: doc/BRIEF.md
# Interleaved-bank buffer strobe generator

This block produces the active-low enable and direction strobes for the external buffers of a memory built from two interleaved banks, A and B. There are three strobe families: data transmit, data chip enable and instruction transmit. Each family has one combined output that covers both banks and one output per bank. A controller raises `cyc_act` for as long as a memory cycle runs, and tells the block whether the cycle is simple pipelined or burst (`cyc_burst`) and whether it reads or writes (`cyc_rd`). The asynchronous `nxt_bank_b` input names the bank that the next cycle starts on.

On the first active clock the block latches the cycle type, the direction and the synchronized starting bank. A simple cycle stays on that bank. A burst moves to the other bank on every beat. Each combined strobe covers every beat of the cycle. The per-bank strobes follow the accessed bank. The one exception is a burst write, which holds both per-bank chip enables for the whole burst. All strobes are registered and change on the same clock edge that samples `cyc_act`.

The state machine has three states. ST_IDLE means no cycle is in progress. ST_SIMPLE is a simple pipelined cycle on one bank. ST_BURST is a burst that alternates banks. There are four transitions. START_SIMPLE goes from ST_IDLE to ST_SIMPLE when `cyc_act` is high and `cyc_burst` is low. START_BURST goes from ST_IDLE to ST_BURST when `cyc_act` and `cyc_burst` are both high. END_SIMPLE goes from ST_SIMPLE to ST_IDLE when `cyc_act` is low. END_BURST goes from ST_BURST to ST_IDLE when `cyc_act` is low. While `cyc_act` stays high, each active state holds, and ST_BURST toggles the bank on every clock.

Top module: `bank_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and on any clock edge that samples `cyc_act` low, all nine strobe outputs are high (deasserted).
- R2: `nxt_bank_b` (1 = bank B, 0 = bank A) passes through SYNC_STAGES (default 2) flip-flops before use. A change applied in the same clock period as the start of a cycle is not seen by that cycle, which starts on the previous value.
- R3: The first beat accesses the synchronized bank. In a burst the accessed bank flips on every following beat. A simple cycle stays on its first bank.
- R4: In a simple read, `dtx_n`, `itx_n` and `dce_n` are low, and of the per-bank outputs only the three that belong to the accessed bank are low.
- R5: In a simple write, `dce_n` and the accessed bank's chip enable are low, and all six transmit outputs are high.
- R6: In a burst read, the three combined outputs are low on every beat, and on each beat only the accessed bank's per-bank outputs of all three families are low.
- R7: In a burst write, `dce_n`, `dce_a_n` and `dce_b_n` are low on every beat, and all six transmit outputs are high.
- R8: Cycle type and direction are taken only on the first beat. Changing `cyc_burst`, `cyc_rd` or `nxt_bank_b` during a cycle has no effect on that cycle's strobes.
- R9: Strobes take their beat value on the clock edge that samples `cyc_act` high. They return high on the first edge that samples it low. A new cycle may start one clock after the previous one ends.
- R10: The two per-bank transmit outputs of a family are never low together. A per-bank output of any family is low only while its family's combined output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_act | input | 1 | High while a memory cycle is in progress |
| cyc_burst | input | 1 | 1 = burst cycle, 0 = simple pipelined cycle |
| cyc_rd | input | 1 | 1 = read, 0 = write |
| nxt_bank_b | input | 1 | Asynchronous next-bank select, 1 = bank B |
| dtx_n | output | 1 | Data transmit, combined |
| dtx_a_n | output | 1 | Data transmit, bank A |
| dtx_b_n | output | 1 | Data transmit, bank B |
| dce_n | output | 1 | Data buffer chip enable, combined |
| dce_a_n | output | 1 | Data buffer chip enable, bank A |
| dce_b_n | output | 1 | Data buffer chip enable, bank B |
| itx_n | output | 1 | Instruction transmit, combined |
| itx_a_n | output | 1 | Instruction transmit, bank A |
| itx_b_n | output | 1 | Instruction transmit, bank B |

## Verification
The assertions assume that `cyc_act`, `cyc_burst` and `cyc_rd` are synchronous to `clk` and free of glitches at the sampling edge. They also assume that `nxt_bank_b` is settled for more than SYNC_STAGES clocks before a cycle starts whenever the starting bank matters. The stimulus changes every input half a period away from the active edge. Before each checked cycle it holds the bank select for three idle clocks. The single exception is a deliberate same-period change that shows the synchronizer delay. Mid-cycle toggles of the type, direction and bank inputs are applied only after the first beat has been latched.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

    localparam int BSG_NUM_BANKS = 2;
    localparam int BSG_BANK_A    = 0;
    localparam int BSG_BANK_B    = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SIMPLE = 2'd1,
        ST_BURST  = 2'd2
    } bsg_state_e;

    // One strobe family: combined output plus one per bank, all active-low
    typedef struct packed {
        logic                     all_n;
        logic [BSG_NUM_BANKS-1:0] bank_n;
    } bsg_fam_t;

    localparam bsg_fam_t BSG_FAM_OFF = '{all_n: 1'b1, bank_n: '1};

endpackage

// File: rtl/bsg_sync.sv
module bsg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar gs = 0; gs < STAGES; gs++) begin : g_stage
            if (gs == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gs] <= 1'b0;
                    else        chain_q[gs] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gs] <= 1'b0;
                    else        chain_q[gs] <= chain_q[gs-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[LAST];

endmodule

// File: rtl/bsg_fsm.sv
module bsg_fsm
    import bsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_act,
    input  logic       cyc_burst,
    input  logic       cyc_rd,
    input  logic       bank_sync,
    output bsg_state_e state_nx,
    output logic       bank_nx,
    output logic       rd_nx
);
    bsg_state_e state_q;
    logic       bank_q;
    logic       rd_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_nx;
            bank_q  <= bank_nx;
            rd_q    <= rd_nx;
        end
    end

    // Next state: type, direction and first bank latched on START_*
    always_comb begin
        state_nx = state_q;
        bank_nx  = bank_q;
        rd_nx    = rd_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cyc_act) begin
                    state_nx = cyc_burst ? ST_BURST : ST_SIMPLE;
                    bank_nx  = bank_sync;
                    rd_nx    = cyc_rd;
                end
            end
            ST_SIMPLE: begin
                if (!cyc_act) state_nx = ST_IDLE;
            end
            ST_BURST: begin
                if (!cyc_act) state_nx = ST_IDLE;
                else          bank_nx  = ~bank_q;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/bsg_strobe_out.sv
module bsg_strobe_out
    import bsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bsg_state_e state_nx,
    input  logic       bank_nx,
    input  logic       rd_nx,
    output bsg_fam_t   dtx_q,
    output bsg_fam_t   dce_q,
    output bsg_fam_t   itx_q
);
    logic [BSG_NUM_BANKS-1:0] hit;
    bsg_fam_t dtx_d, dce_d, itx_d;

    generate
        for (genvar gb = 0; gb < BSG_NUM_BANKS; gb++) begin : g_hit
            assign hit[gb] = (bank_nx == 1'(gb));
        end
    endgenerate

    // Output decode from the state being entered
    always_comb begin
        dtx_d = BSG_FAM_OFF;
        dce_d = BSG_FAM_OFF;
        itx_d = BSG_FAM_OFF;
        unique case (state_nx)
            ST_IDLE: ;
            ST_SIMPLE: begin
                dce_d.all_n  = 1'b0;
                dce_d.bank_n = ~hit;
                if (rd_nx) begin
                    dtx_d.all_n  = 1'b0;
                    dtx_d.bank_n = ~hit;
                    itx_d.all_n  = 1'b0;
                    itx_d.bank_n = ~hit;
                end
            end
            ST_BURST: begin
                dce_d.all_n = 1'b0;
                if (rd_nx) begin
                    dce_d.bank_n = ~hit;
                    dtx_d.all_n  = 1'b0;
                    dtx_d.bank_n = ~hit;
                    itx_d.all_n  = 1'b0;
                    itx_d.bank_n = ~hit;
                end else begin
                    dce_d.bank_n = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dtx_q <= BSG_FAM_OFF;
            dce_q <= BSG_FAM_OFF;
            itx_q <= BSG_FAM_OFF;
        end else begin
            dtx_q <= dtx_d;
            dce_q <= dce_d;
            itx_q <= itx_d;
        end
    end

endmodule

// File: rtl/bank_strobe_gen.sv
module bank_strobe_gen
    import bsg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_act,
    input  logic cyc_burst,
    input  logic cyc_rd,
    input  logic nxt_bank_b,
    output logic dtx_n,
    output logic dtx_a_n,
    output logic dtx_b_n,
    output logic dce_n,
    output logic dce_a_n,
    output logic dce_b_n,
    output logic itx_n,
    output logic itx_a_n,
    output logic itx_b_n
);
    logic       bank_sync;
    bsg_state_e state_nx;
    logic       bank_nx;
    logic       rd_nx;
    bsg_fam_t   dtx_q, dce_q, itx_q;

    bsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (nxt_bank_b),
        .q_sync  (bank_sync)
    );

    bsg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_act   (cyc_act),
        .cyc_burst (cyc_burst),
        .cyc_rd    (cyc_rd),
        .bank_sync (bank_sync),
        .state_nx  (state_nx),
        .bank_nx   (bank_nx),
        .rd_nx     (rd_nx)
    );

    bsg_strobe_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_nx (state_nx),
        .bank_nx  (bank_nx),
        .rd_nx    (rd_nx),
        .dtx_q    (dtx_q),
        .dce_q    (dce_q),
        .itx_q    (itx_q)
    );

    assign dtx_n   = dtx_q.all_n;
    assign dtx_a_n = dtx_q.bank_n[BSG_BANK_A];
    assign dtx_b_n = dtx_q.bank_n[BSG_BANK_B];
    assign dce_n   = dce_q.all_n;
    assign dce_a_n = dce_q.bank_n[BSG_BANK_A];
    assign dce_b_n = dce_q.bank_n[BSG_BANK_B];
    assign itx_n   = itx_q.all_n;
    assign itx_a_n = itx_q.bank_n[BSG_BANK_A];
    assign itx_b_n = itx_q.bank_n[BSG_BANK_B];

endmodule

// File: rtl/bsg_checker.sv
module bsg_checker (
    input logic clk,
    input logic rst_n,
    input logic cyc_act,
    input logic dtx_n,
    input logic dtx_a_n,
    input logic dtx_b_n,
    input logic dce_n,
    input logic dce_a_n,
    input logic dce_b_n,
    input logic itx_n,
    input logic itx_a_n,
    input logic itx_b_n
);
    a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cyc_act) |-> (dtx_n && dtx_a_n && dtx_b_n && dce_n && dce_a_n
                             && dce_b_n && itx_n && itx_a_n && itx_b_n));

    a_r10_dtx_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~dtx_a_n, ~dtx_b_n}));

    a_r10_itx_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~itx_a_n, ~itx_b_n}));

    a_r10_bank_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
        ((!dtx_a_n || !dtx_b_n) |-> !dtx_n) and
        ((!dce_a_n || !dce_b_n) |-> !dce_n) and
        ((!itx_a_n || !itx_b_n) |-> !itx_n));

    a_r7_dual_ce_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (!dce_a_n && !dce_b_n) |-> (dtx_n && itx_n));

    a_r4_tx_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtx_n || !itx_n) |-> !dce_n);

    a_r9_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dce_n) |-> !$past(cyc_act));

endmodule

bind bank_strobe_gen bsg_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_act (cyc_act),
    .dtx_n   (dtx_n),
    .dtx_a_n (dtx_a_n),
    .dtx_b_n (dtx_b_n),
    .dce_n   (dce_n),
    .dce_a_n (dce_a_n),
    .dce_b_n (dce_b_n),
    .itx_n   (itx_n),
    .itx_a_n (itx_a_n),
    .itx_b_n (itx_b_n)
);

// File: tb/bank_strobe_gen_tb.sv
module bank_strobe_gen_tb;

    typedef struct {
        logic [8:0] vec;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_act = 1'b0;
    logic cyc_burst = 1'b0;
    logic cyc_rd = 1'b0;
    logic nxt_bank_b = 1'b0;
    logic dtx_n, dtx_a_n, dtx_b_n, dce_n, dce_a_n, dce_b_n, itx_n, itx_a_n, itx_b_n;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    bank_strobe_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_act(cyc_act), .cyc_burst(cyc_burst),
        .cyc_rd(cyc_rd), .nxt_bank_b(nxt_bank_b),
        .dtx_n(dtx_n), .dtx_a_n(dtx_a_n), .dtx_b_n(dtx_b_n),
        .dce_n(dce_n), .dce_a_n(dce_a_n), .dce_b_n(dce_b_n),
        .itx_n(itx_n), .itx_a_n(itx_a_n), .itx_b_n(itx_b_n)
    );

    // Bit order: itx_b itx_a itx dce_b dce_a dce dtx_b dtx_a dtx
    function automatic logic [8:0] obs();
        return {itx_b_n, itx_a_n, itx_n, dce_b_n, dce_a_n, dce_n, dtx_b_n, dtx_a_n, dtx_n};
    endfunction

    // Expected active-low strobes from R1, R4-R7
    function automatic logic [8:0] exp_vec(bit act, bit burst, bit rd, bit bank);
        logic tx, txa, txb, ce, cea, ceb;
        if (!act) return 9'h1FF;
        tx  = rd;
        txa = rd && !bank;
        txb = rd && bank;
        ce  = 1'b1;
        if (burst && !rd) begin
            cea = 1'b1; ceb = 1'b1;
        end else begin
            cea = !bank; ceb = bank;
        end
        return ~{txb, txa, tx, ceb, cea, ce, txb, txa, tx};
    endfunction

    function automatic string cyc_tag(bit burst, bit rd);
        if (!burst) return rd ? "R4" : "R5";
        return rd ? "R6" : "R7";
    endfunction

    task automatic push(logic [8:0] v, string t);
        exp_t e;
        e.vec = v;
        e.tag = t;
        sb_q.push_back(e);
    endtask

    task automatic idle(int n, string t);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_act = 1'b0;
            push(9'h1FF, t);
        end
    endtask

    // Driver: one memory cycle; chg toggles type, direction and bank mid-cycle (R8)
    task automatic run_cyc(bit burst, bit rd, bit bank, int beats, bit chg);
        bit b;
        string t;
        @(negedge clk);
        nxt_bank_b = bank;
        cyc_act = 1'b0;
        push(9'h1FF, "R1");
        idle(3, "R1");
        b = bank;
        for (int k = 0; k < beats; k++) begin
            @(negedge clk);
            cyc_act = 1'b1;
            if (k == 0) begin
                cyc_burst = burst;
                cyc_rd    = rd;
            end else if (chg) begin
                cyc_burst  = ~cyc_burst;
                cyc_rd     = ~cyc_rd;
                nxt_bank_b = ~nxt_bank_b;
            end
            t = chg ? "R8" : (k == 0 ? "R9" : (burst ? "R3" : cyc_tag(burst, rd)));
            push(exp_vec(1'b1, burst, rd, b), t);
            if (burst) b = ~b;
        end
        @(negedge clk);
        cyc_act = 1'b0;
        push(9'h1FF, "R1");
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (obs() !== e.vec) begin
                    n_fail++;
                    $display("FAIL %s: strobes actual %b expected %b", e.tag, obs(), e.vec);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        n_chk++;
        if (obs() !== 9'h1FF) begin
            n_fail++;
            $display("FAIL R1: reset strobes actual %b expected %b", obs(), 9'h1FF);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3..R7: all type/direction combos, both start banks
        for (int bu = 0; bu < 2; bu++)
            for (int rd = 0; rd < 2; rd++)
                for (int bk = 0; bk < 2; bk++)
                    run_cyc(bu[0], rd[0], bk[0], bu ? 5 : 3, 1'b0);

        // R8: mid-cycle input changes ignored
        run_cyc(1'b1, 1'b1, 1'b0, 4, 1'b1);
        run_cyc(1'b0, 1'b0, 1'b1, 3, 1'b1);
        run_cyc(1'b1, 1'b0, 1'b1, 4, 1'b1);

        // R2: bank change in the start period is not seen
        @(negedge clk);
        nxt_bank_b = 1'b0;
        push(9'h1FF, "R1");
        idle(3, "R1");
        @(negedge clk);
        nxt_bank_b = 1'b1;
        cyc_act = 1'b1; cyc_burst = 1'b0; cyc_rd = 1'b1;
        push(exp_vec(1'b1, 1'b0, 1'b1, 1'b0), "R2");
        @(negedge clk);
        push(exp_vec(1'b1, 1'b0, 1'b1, 1'b0), "R2");
        // R9: end then restart after one idle clock, new bank now synchronized
        @(negedge clk);
        cyc_act = 1'b0;
        push(9'h1FF, "R9");
        @(negedge clk);
        cyc_act = 1'b1; cyc_burst = 1'b1; cyc_rd = 1'b1;
        push(exp_vec(1'b1, 1'b1, 1'b1, 1'b1), "R9");
        @(negedge clk);
        push(exp_vec(1'b1, 1'b1, 1'b1, 1'b0), "R3");
        @(negedge clk);
        cyc_act = 1'b0;
        push(9'h1FF, "R1");
        idle(2, "R1");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule